// File: doc/BRIEF.md
# Dual-Device Reset Request Dispatcher

This block serves a storage host controller that shows one register view for a master and a slave device. It watches register writes and command issues. It turns the ones that concern resets into per-device requests: a link-initialization request, a soft-reset request, or a command request for a device reset or a diagnostic. The reset source sets which devices get the request and whether the link is involved. A soft reset goes to both devices and never touches the link. A write of the detect field starts link initialization on both devices. A device-reset command reaches only the selected device. A diagnostic command reaches both devices.

Each device has its own busy flag. The flag is raised when a request is issued to that device. It drops when the device reports, with a completion pulse, that its register frame has arrived. A new request to a busy device is dropped. The block holds no frame contents and does no link signalling. The hardware reset input clears all state, which covers both devices at once.

Top module: `dual_reset_dispatch`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, every request output, `cmd_diag` and `busy` are zero.
- R2: A write to address 0 with bit 2 set, when the previously stored bit 2 was 0, pulses `soft_rst_req` for one cycle on every idle device, beginning the cycle after the write. `link_init_req` does not change.
- R3: A write to address 0 that has bit 2 set while the stored bit 2 is already 1 issues nothing. Writing 0 to bit 2 re-arms the soft reset.
- R4: A write to address 1 whose low four bits equal 1, when the stored detect value was not 1, sets `link_init_req` on every idle device. The request is held until a write to address 1 with any other low-nibble value clears it on both devices.
- R5: A further write of detect value 1 while detect is already 1 issues no new request, even to devices that have since become idle.
- R6: Opcode 0x08 on `cmd_valid` pulses `cmd_req` for one cycle only toward the device chosen by bit 4 of the last write to address 2 (0 = master = bit 0, 1 = slave = bit 1), with `cmd_diag` low.
- R7: Opcode 0x90 pulses `cmd_req` toward both idle devices with `cmd_diag` high.
- R8: Any other opcode has no effect on requests or busy flags.
- R9: `busy[i]` rises in the cycle that a request to device i appears, and it falls only in the cycle after a `done[i]` pulse. A `done` pulse for the other device leaves it unchanged.
- R10: A request of any kind toward a busy device is dropped: no output pulse, and the device stays busy. Idle devices named by the same request still get it.
- R11: When sources coincide in one cycle, link initialization takes a device before soft reset, and soft reset before a command. A device takes at most one new request per cycle.
- R12: A `done` pulse to an idle device has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset, clears all state |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | 0 device control, 1 link control, 2 device select |
| reg_wdata | input | 8 | Write data |
| cmd_valid | input | 1 | Command issue strobe |
| cmd_op | input | 8 | Command opcode |
| done | input | 2 | Per-device completion pulse (bit 0 master, bit 1 slave) |
| link_init_req | output | 2 | Held link-initialization request per device |
| soft_rst_req | output | 2 | One-cycle soft-reset request per device |
| cmd_req | output | 2 | One-cycle command request per device |
| cmd_diag | output | 1 | Marks the current `cmd_req` as a diagnostic |
| busy | output | 2 | Per-device wait-for-completion flag |

## Verification
The bench rewrites a held soft-reset bit and a held detect value. A design that triggers on level instead of on the edge would issue a second reset there. It sends device-reset commands with device-select data whose other bits are set, so a decoder that reads the wrong bit would reach the wrong device. It sends a diagnostic while one device is busy, to show that only the idle one is served. It also issues a detect write and a diagnostic in the same cycle, where a wrong priority would let the command through. Completion pulses go to one device at a time and to idle devices, to catch flags that clear together or that toggle.

// File: rtl/dual_reset_dispatch.sv
module dual_reset_dispatch #(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8,
  parameter int OP_W = 8,
  parameter int SRST_POS = 2,
  parameter int SEL_POS = 4,
  parameter int DET_W = 4,
  parameter logic [ADDR_W-1:0] A_CTL = 0,
  parameter logic [ADDR_W-1:0] A_LINK = 1,
  parameter logic [ADDR_W-1:0] A_SEL = 2,
  parameter logic [OP_W-1:0] OP_DEVRST = 8'h08,
  parameter logic [OP_W-1:0] OP_DIAG = 8'h90
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              cmd_valid,
  input  logic [OP_W-1:0]   cmd_op,
  input  logic [1:0]        done,
  output logic [1:0]        link_init_req,
  output logic [1:0]        soft_rst_req,
  output logic [1:0]        cmd_req,
  output logic              cmd_diag,
  output logic [1:0]        busy
);
  localparam logic [DET_W-1:0] DET_GO = DET_W'(1);

  logic srst_q, det_q, sel_q;

  wire wr_ctl  = reg_wr && reg_addr == A_CTL;
  wire wr_link = reg_wr && reg_addr == A_LINK;
  wire wr_sel  = reg_wr && reg_addr == A_SEL;
  wire det_one = reg_wdata[DET_W-1:0] == DET_GO;

  wire srst_edge = wr_ctl && reg_wdata[SRST_POS] && !srst_q;
  wire det_start = wr_link && det_one && !det_q;
  wire det_stop  = wr_link && !det_one;
  wire is_rst    = cmd_valid && cmd_op == OP_DEVRST;
  wire is_diag   = cmd_valid && cmd_op == OP_DIAG;

  wire [1:0] want_cmd = is_diag ? 2'b11 : is_rst ? (sel_q ? 2'b10 : 2'b01) : 2'b00;
  wire [1:0] link_new = {2{det_start}} & ~busy;
  wire [1:0] soft_new = {2{srst_edge}} & ~busy & ~link_new;
  wire [1:0] cmd_new  = want_cmd & ~busy & ~link_new & ~soft_new;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srst_q <= 1'b0;
      det_q <= 1'b0;
      sel_q <= 1'b0;
      busy <= '0;
      link_init_req <= '0;
      soft_rst_req <= '0;
      cmd_req <= '0;
      cmd_diag <= 1'b0;
    end else begin
      if (wr_ctl) srst_q <= reg_wdata[SRST_POS];
      if (wr_link) det_q <= det_one;
      if (wr_sel) sel_q <= reg_wdata[SEL_POS];
      busy <= (busy & ~done) | link_new | soft_new | cmd_new;
      link_init_req <= det_stop ? 2'b00 : (link_init_req | link_new);
      soft_rst_req <= soft_new;
      cmd_req <= cmd_new;
      cmd_diag <= is_diag && (cmd_new != 2'b00);
    end
  end
endmodule

// File: rtl/dual_reset_dispatch_chk.sv
module dual_reset_dispatch_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] done,
  input logic [1:0] link_init_req,
  input logic [1:0] soft_rst_req,
  input logic [1:0] cmd_req,
  input logic       cmd_diag,
  input logic [1:0] busy
);
  // R2
  soft_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_req != 2'b00 |=> soft_rst_req == 2'b00);
  // R2
  soft_no_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_req != 2'b00 |-> $stable(link_init_req));
  // R6
  devrst_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req != 2'b00 && !cmd_diag) |-> $countones(cmd_req) == 1);
  // R7
  diag_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_diag |-> cmd_req != 2'b00);
  // R10
  idle_m_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst_req[0] || cmd_req[0]) |-> busy[0] && !$past(busy[0]));
  // R10
  idle_s_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst_req[1] || cmd_req[1]) |-> busy[1] && !$past(busy[1]));
  // R9
  clear_m_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy[0]) |-> $past(done[0]));
  // R9
  clear_s_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy[1]) |-> $past(done[1]));
  // R11
  one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({soft_rst_req[0], cmd_req[0]}) && $onehot0({soft_rst_req[1], cmd_req[1]}));
endmodule

bind dual_reset_dispatch dual_reset_dispatch_chk chk (
  .clk(clk), .rst_n(rst_n), .done(done), .link_init_req(link_init_req),
  .soft_rst_req(soft_rst_req), .cmd_req(cmd_req), .cmd_diag(cmd_diag), .busy(busy)
);

// File: tb/dual_reset_dispatch_test.sv
module dual_reset_dispatch_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic cmd_valid = 1'b0;
  logic [7:0] cmd_op = '0;
  logic [1:0] done = '0;
  logic [1:0] link_init_req, soft_rst_req, cmd_req, busy;
  logic cmd_diag;
  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  dual_reset_dispatch uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .done(done),
    .link_init_req(link_init_req), .soft_rst_req(soft_rst_req), .cmd_req(cmd_req),
    .cmd_diag(cmd_diag), .busy(busy)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(logic w, logic [1:0] a, logic [7:0] d, logic cv, logic [7:0] op, logic [1:0] dn);
    @(negedge clk);
    reg_wr = w; reg_addr = a; reg_wdata = d; cmd_valid = cv; cmd_op = op; done = dn;
    @(negedge clk);
    reg_wr = 0; cmd_valid = 0; done = 0;
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d); step(1, a, d, 0, 0, 0); endtask
  task automatic cmd(logic [7:0] op); step(0, 0, 0, 1, op, 0); endtask
  task automatic fin(logic [1:0] dn); step(0, 0, 0, 0, 0, dn); endtask

  task automatic t_reset;
    chk("R1 link", {6'd0, link_init_req}, 0);
    chk("R1 soft", {6'd0, soft_rst_req}, 0);
    chk("R1 cmd", {5'd0, cmd_diag, cmd_req}, 0);
    chk("R1 busy", {6'd0, busy}, 0);
  endtask

  task automatic t_soft;
    wr(0, 8'h04);
    chk("R2 soft both", {6'd0, soft_rst_req}, 8'h03);
    chk("R2 no link", {6'd0, link_init_req}, 0);
    chk("R9 busy set", {6'd0, busy}, 8'h03);
    @(negedge clk);
    chk("R2 one cycle", {6'd0, soft_rst_req}, 0);
    fin(2'b01);
    chk("R9 master only", {6'd0, busy}, 8'h02);
    fin(2'b10);
    chk("R9 slave clear", {6'd0, busy}, 0);
    wr(0, 8'h04);
    chk("R3 held one", {6'd0, soft_rst_req}, 0);
    chk("R3 busy idle", {6'd0, busy}, 0);
    wr(0, 8'h00);
    wr(0, 8'h04);
    chk("R3 rearm", {6'd0, soft_rst_req}, 8'h03);
    fin(2'b11);
    wr(0, 8'h00);
  endtask

  task automatic t_link;
    wr(1, 8'h01);
    chk("R4 link set", {6'd0, link_init_req}, 8'h03);
    chk("R4 busy", {6'd0, busy}, 8'h03);
    chk("R4 no soft", {6'd0, soft_rst_req}, 0);
    fin(2'b11);
    chk("R4 held", {6'd0, link_init_req}, 8'h03);
    wr(1, 8'h01);
    chk("R5 no retrigger", {6'd0, busy}, 0);
    wr(1, 8'h00);
    chk("R4 released", {6'd0, link_init_req}, 0);
  endtask

  task automatic t_devrst;
    wr(2, 8'h00);
    cmd(8'h08);
    chk("R6 master", {5'd0, cmd_diag, cmd_req}, 8'h01);
    fin(2'b01);
    wr(2, 8'h10);
    cmd(8'h08);
    chk("R6 slave", {5'd0, cmd_diag, cmd_req}, 8'h02);
    chk("R6 busy slave", {6'd0, busy}, 8'h02);
    fin(2'b10);
    wr(2, 8'hEF);
    cmd(8'h08);
    chk("R6 bit4 only", {5'd0, cmd_diag, cmd_req}, 8'h01);
    fin(2'b01);
  endtask

  task automatic t_diag;
    cmd(8'h90);
    chk("R7 diag both", {5'd0, cmd_diag, cmd_req}, 8'h07);
    fin(2'b11);
    chk("R7 cleared", {6'd0, busy}, 0);
  endtask

  task automatic t_other;
    cmd(8'h00);
    chk("R8 op00", {4'd0, busy, cmd_req}, 0);
    cmd(8'h91);
    chk("R8 op91", {4'd0, busy, cmd_req}, 0);
    cmd(8'h18);
    chk("R8 op18", {4'd0, busy, cmd_req}, 0);
  endtask

  task automatic t_busy;
    wr(2, 8'h00);
    cmd(8'h08);
    cmd(8'h90);
    chk("R10 diag slave only", {5'd0, cmd_diag, cmd_req}, 8'h06);
    chk("R10 busy both", {6'd0, busy}, 8'h03);
    wr(0, 8'h04);
    chk("R10 soft dropped", {6'd0, soft_rst_req}, 0);
    fin(2'b11);
    wr(0, 8'h00);
    fin(2'b01);
    chk("R12 idle done", {6'd0, busy}, 0);
    cmd(8'h08);
    chk("R12 still works", {6'd0, cmd_req}, 8'h01);
    fin(2'b01);
  endtask

  task automatic t_prio;
    step(1, 1, 8'h01, 1, 8'h90, 0);
    chk("R11 link wins", {6'd0, link_init_req}, 8'h03);
    chk("R11 cmd dropped", {5'd0, cmd_diag, cmd_req}, 0);
    chk("R11 busy", {6'd0, busy}, 8'h03);
    wr(1, 8'h00);
    fin(2'b11);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_soft();
    t_link();
    t_devrst();
    t_diag();
    t_other();
    t_busy();
    t_prio();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule